// File: doc/BRIEF.md
# ADC Result Buffer Controller

This block sits behind an analog-to-digital converter front end. Each converted sample arrives with a valid strobe and the number of the channel it came from. The block writes the sample into a small result buffer and pulses an interrupt once software's chosen number of samples has been gathered. Software reads any slot of the buffer through a combinational read port.

A small control register sets the sample count and the storage policy. In plain FIFO order, each group of samples fills the buffer from slot 0 upward. In split mode the buffer acts as two halves that take turns: the converter fills one half while software drains the other, and a status bit reports which half is being filled. In channel-indexed mode every sample lands in the slot whose number equals its channel, so the buffer always holds the latest result of each channel.

Top module: `adc_result_buffer`

## Requirements
- R1: After reset, every control field reads 0, the interrupt and fill-status outputs are 0 and every buffer slot reads 0.
- R2: A control write loads the count field N from cfg_wdata[4:0], the split bit from cfg_wdata[5] and the channel-indexed bit from cfg_wdata[6]. cfg_rdata returns those fields at the same positions, and the fill-status bit sits at cfg_rdata[7].
- R3: With the indexed bit at 0, accepted samples go to consecutive slots. A stored value reads back on rd_data from the cycle after the sample.
- R4: irq is a one-cycle pulse, one clock after the sample that completes a group of N+1 accepted samples. N=0 gives a pulse for every sample and N=31 gives a pulse for every 32nd sample.
- R5: With split=0 and indexed=0, the first sample after each interrupt is stored in slot 0.
- R6: With split=1 and indexed=0, filling starts in the lower half (slots 0-15). Each interrupt moves the pointer to the base of the other half (slot 16 or slot 0) and toggles the fill-status bit, which is 1 while the upper half is filled. Inside a half, the pointer wraps from the top slot of that half back to its base.
- R7: With indexed=1, each sample is stored in the slot numbered by smp_chan, and the interrupt still fires every N+1 samples.
- R8: A control write clears the sample counter, returns the FIFO pointer to slot 0 and clears fill status. A sample accepted in the same cycle is stored at the address chosen under the old settings, is not counted and raises no interrupt.
- R9: With indexed=1, the split bit has no effect: fill status stays 0 through every interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 7 | Control write data: N[4:0], split[5], indexed[6] |
| cfg_rdata | output | 8 | Control readback plus fill status in bit 7 |
| smp_valid | input | 1 | A converted sample is present this cycle |
| smp_chan | input | 5 | Channel number of the sample |
| smp_data | input | 12 | Converted sample value |
| rd_addr | input | 5 | Buffer slot to read |
| rd_data | output | 12 | Content of slot rd_addr |
| irq | output | 1 | Group-complete interrupt pulse |
| fill_upper | output | 1 | 1 while the upper half is being filled |

## Verification
The bench drives N=0, N=3 and N=31. An off-by-one counter shows up there as an interrupt one sample early or late. In split mode it uses N=19, which makes the pointer wrap inside the half before the interrupt; a design that let the pointer run into the other half overwrites data software is still reading. Indexed mode runs with the split bit set, so a design that toggles fill status there is caught. A control write that coincides with a sample checks that the sample still lands where the old settings put it and neither counts nor interrupts; a design that got this wrong would fire a stray interrupt or drop the sample.

// File: rtl/adcbuf_pkg.sv
package adcbuf_pkg;
    // Width of the sample-count field; fixed by the control register layout.
    localparam int CNT_W = 5;

    typedef struct packed {
        logic             indexed;
        logic             split;
        logic [CNT_W-1:0] n;
    } ctrl_t;
endpackage

// File: rtl/adcbuf_ctrl_reg.sv
module adcbuf_ctrl_reg
    import adcbuf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [CNT_W+1:0]     cfg_wdata,
    output ctrl_t                ctrl
);
    typedef struct packed {
        ctrl_t ctrl;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.ctrl.n       = cfg_wdata[CNT_W-1:0];
            st_d.ctrl.split   = cfg_wdata[CNT_W];
            st_d.ctrl.indexed = cfg_wdata[CNT_W+1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl = st_q.ctrl;

    // R2
    hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(ctrl));
endmodule

// File: rtl/adcbuf_sequencer.sv
module adcbuf_sequencer
    import adcbuf_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  ctrl_t                    ctrl,
    input  logic                     cfg_wr,
    input  logic                     smp_valid,
    input  logic [$clog2(DEPTH)-1:0] smp_chan,
    output logic                     wr_en,
    output logic [$clog2(DEPTH)-1:0] wr_addr,
    output logic                     irq,
    output logic                     fill_upper
);
    localparam int AW   = $clog2(DEPTH);
    localparam int HW   = AW - 1;

    typedef struct packed {
        logic [AW-1:0]    ptr;
        logic [CNT_W-1:0] cnt;
        logic             irq;
        logic             fill;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       group_done;
    logic [HW-1:0] low_next;

    always_comb begin
        st_d       = st_q;
        st_d.irq   = 1'b0;
        wr_en      = smp_valid;
        wr_addr    = ctrl.indexed ? smp_chan : st_q.ptr;
        group_done = smp_valid && (st_q.cnt == ctrl.n);
        low_next   = st_q.ptr[HW-1:0] + 1'b1;

        if (cfg_wr) begin
            st_d.ptr  = '0;
            st_d.cnt  = '0;
            st_d.fill = 1'b0;
        end else if (smp_valid) begin
            if (!ctrl.indexed) begin
                if (ctrl.split) st_d.ptr = {st_q.ptr[AW-1], low_next};
                else            st_d.ptr = st_q.ptr + 1'b1;
            end
            if (group_done) begin
                st_d.cnt = '0;
                st_d.irq = 1'b1;
                if (!ctrl.indexed) begin
                    if (ctrl.split) begin
                        st_d.fill = ~st_q.fill;
                        st_d.ptr  = {~st_q.fill, {HW{1'b0}}};
                    end else begin
                        st_d.ptr  = '0;
                    end
                end
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq        = st_q.irq;
    assign fill_upper = st_q.fill;

    // R4
    irq_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(smp_valid) && !$past(cfg_wr)));

    // R8
    cfg_clears_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (st_q.cnt == '0 && st_q.ptr == '0 && !irq));

    // R6
    fill_moves_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(fill_upper) && !$past(cfg_wr)) |-> irq);

    // R6
    ptr_in_fill_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.split && !ctrl.indexed) |-> (st_q.ptr[AW-1] == fill_upper));

    // R9
    fill_idle_unless_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.split || ctrl.indexed) |-> !fill_upper);
endmodule

// File: rtl/adcbuf_store.sv
module adcbuf_store #(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-1:0] wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [DATA_W-1:0]        rd_data
);
    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] slot;
    } store_state_t;

    store_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) st_d.slot[wr_addr] = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.slot[rd_addr];

    // R3
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (st_q.slot[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/adc_result_buffer.sv
module adc_result_buffer
    import adcbuf_pkg::*;
#(
    parameter int DEPTH  = 32,
    parameter int DATA_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_wr,
    input  logic [CNT_W+1:0]         cfg_wdata,
    output logic [CNT_W+2:0]         cfg_rdata,
    input  logic                     smp_valid,
    input  logic [$clog2(DEPTH)-1:0] smp_chan,
    input  logic [DATA_W-1:0]        smp_data,
    input  logic [$clog2(DEPTH)-1:0] rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     irq,
    output logic                     fill_upper
);
    localparam int AW = $clog2(DEPTH);

    ctrl_t         ctrl;
    logic          wr_en;
    logic [AW-1:0] wr_addr;

    adcbuf_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .ctrl      (ctrl)
    );

    adcbuf_sequencer #(.DEPTH(DEPTH)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl       (ctrl),
        .cfg_wr     (cfg_wr),
        .smp_valid  (smp_valid),
        .smp_chan   (smp_chan),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .irq        (irq),
        .fill_upper (fill_upper)
    );

    adcbuf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (smp_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign cfg_rdata = {fill_upper, ctrl.indexed, ctrl.split, ctrl.n};
endmodule

// File: tb/tb_adc_result_buffer.sv
module tb_adc_result_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [6:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        smp_valid = 1'b0;
    logic [4:0]  smp_chan = '0;
    logic [11:0] smp_data = '0;
    logic [4:0]  rd_addr = '0;
    logic [11:0] rd_data;
    logic        irq;
    logic        fill_upper;

    adc_result_buffer dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .smp_valid(smp_valid), .smp_chan(smp_chan),
        .smp_data(smp_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq(irq), .fill_upper(fill_upper)
    );

    always #5 clk = ~clk;

    int tests = 0;
    int fails = 0;

    // Reference model: state expected after the most recent clock edge.
    int m_mem [32];
    int m_n = 0, m_split = 0, m_idx = 0;
    int m_ptr = 0, m_cnt = 0, m_fill = 0, m_irq = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic compare_ports();
        check("R4", "irq", int'(irq), m_irq);
        check((m_idx != 0) ? "R9" : "R6", "fill_upper", int'(fill_upper), m_fill);
        check("R2", "cfg_rdata", int'(cfg_rdata),
              (m_fill << 7) | (m_idx << 6) | (m_split << 5) | m_n);
    endtask

    // Behavioural update of the model for one edge with the given inputs.
    task automatic model_edge(input int v, input int ch, input int d, input int wr, input int wd);
        int addr;
        m_irq = 0;
        if (v != 0) begin
            addr = (m_idx != 0) ? ch : m_ptr;
            m_mem[addr] = d;
        end
        if (wr != 0) begin
            m_n = wd % 32; m_split = (wd / 32) % 2; m_idx = (wd / 64) % 2;
            m_ptr = 0; m_cnt = 0; m_fill = 0;
        end else if (v != 0) begin
            if (m_idx == 0) begin
                if (m_split != 0) m_ptr = (m_ptr / 16) * 16 + ((m_ptr % 16) + 1) % 16;
                else              m_ptr = (m_ptr + 1) % 32;
            end
            m_cnt++;
            if (m_cnt == m_n + 1) begin
                m_cnt = 0;
                m_irq = 1;
                if (m_idx == 0) begin
                    if (m_split != 0) begin
                        m_fill = 1 - m_fill;
                        m_ptr  = m_fill * 16;
                    end else begin
                        m_ptr = 0;
                    end
                end
            end
        end
    endtask

    task automatic step(input int v, input int ch, input int d, input int wr, input int wd);
        @(negedge clk);
        compare_ports();
        smp_valid = v[0]; smp_chan = ch[4:0]; smp_data = d[11:0];
        cfg_wr = wr[0]; cfg_wdata = wd[6:0];
        model_edge(v, ch, d, wr, wd);
    endtask

    task automatic readback(input string req);
        step(0, 0, 0, 0, 0);
        for (int a = 0; a < 32; a++) begin
            rd_addr = a[4:0];
            #1;
            check(req, $sformatf("slot %0d", a), int'(rd_data), m_mem[a]);
        end
    endtask

    task automatic write_cfg(input int wd);
        step(0, 0, 0, 1, wd);
    endtask

    task automatic feed(input int count, input int seed);
        for (int k = 0; k < count; k++)
            step(1, (k * 7 + seed) % 32, (k * 173 + seed * 29 + 5) % 4096, 0, 0);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int a = 0; a < 32; a++) m_mem[a] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of controls, outputs and buffer
        @(negedge clk);
        check("R1", "cfg_rdata", int'(cfg_rdata), 0);
        check("R1", "irq", int'(irq), 0);
        readback("R1");

        // R3 R5: plain FIFO, N=3
        write_cfg(3);
        feed(10, 1);
        readback("R3");
        // R4: N=0 interrupts on every sample
        write_cfg(0);
        feed(6, 2);
        readback("R5");
        // R4: N=31 interrupts on every 32nd sample
        write_cfg(31);
        feed(40, 3);
        readback("R4");

        // R6: split halves, N=3
        write_cfg(32 | 3);
        feed(13, 4);
        readback("R6");
        // R6: N=19 wraps inside a half before the interrupt
        write_cfg(32 | 19);
        feed(45, 5);
        readback("R6");

        // R7 R9: indexed with split set, N=2
        write_cfg(64 | 32 | 2);
        feed(20, 6);
        readback("R7");

        // R8: control write coinciding with a sample
        write_cfg(2);
        feed(2, 7);
        step(1, 0, 3001, 1, 2);
        feed(3, 8);
        step(1, 0, 1234, 1, 64 | 1);
        feed(4, 9);
        readback("R8");

        step(0, 0, 0, 0, 0);
        finish_run();
    end
endmodule